// File: doc/BRIEF.md
# Flash Erase Command Decoder

This block decodes the host write traffic of a parallel NOR flash model and turns the six-write erase sequences into start pulses for an erase engine. Each write is taken at the rising edge of the active-low write strobe. The block finds that edge by comparing the strobe with its own registered copy. Address and data are checked against the value the sequence expects at that step. Any write that does not match sends the decoder back to its array-read state.

The valid prefix has five writes: 0xAA at 0x555, 0x55 at 0x2AA, 0xAA at 0x555 after 0x80 at 0x555, and then 0x55 at 0x2AA. Only the low 11 address bits take part in these compares. The sixth write picks the operation. A write of 0x10 at 0x555 starts a whole-array erase. A write of 0x30 starts a sector erase, and the sector number is taken from the upper address bits of that write. The built-in erase engine is a counter stub, and the busy output stays low until it reports completion. Writes that arrive during an erase are dropped. An active-low reset aborts the erase at once.

Top module: `flash_erase_cmd_decoder`

## Requirements
- R1: While rst_n is low, and right after it is released, busy_n=1, array_read=1, chip_erase_go=0, sect_erase_go=0, sect_target=0 and erase_done=0. The reset is asynchronous and takes effect without waiting for a clock edge.
- R2: The writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555, in that order, produce exactly one chip_erase_go pulse of one cycle. busy_n goes low on the clock edge that accepts the sixth write.
- R3: The same five-write prefix followed by data 0x30 produces exactly one sect_erase_go pulse of one cycle. sect_target then holds bus_addr[ADDR_W-1 -: SECT_W] of the sixth write.
- R4: A write whose address or data differs from the value expected at its step returns the decoder to array read (array_read=1), with no start pulse. A complete sequence written afterwards still starts an erase.
- R5: A write is taken only at a low-to-high transition of we_n, using the bus_addr/bus_data present at that transition. Values presented while we_n stays low or stays high have no effect.
- R6: busy_n stays low for exactly CHIP_LEN+2 clock cycles after a chip erase is accepted, and for exactly SECT_LEN+2 clock cycles after a sector erase is accepted.
- R7: While busy_n is low, every write is ignored, including a complete new sequence. No start pulse appears and the busy time is unchanged.
- R8: At completion, erase_done pulses for one cycle in the last busy cycle. After that, busy_n=1, array_read=1 and sect_target is cleared to 0.
- R9: Pulling rst_n low during an erase raises busy_n immediately. No erase_done follows.
- R10: array_read is 0 while a sequence is partly written and while an erase is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset; aborts an erase |
| we_n | input | 1 | Active-low write strobe; a write is taken on its rising edge |
| bus_addr | input | ADDR_W | Write address |
| bus_data | input | 8 | Write data |
| array_read | output | 1 | High when idle in array-read mode |
| busy_n | output | 1 | Low while an erase is running |
| chip_erase_go | output | 1 | One-cycle pulse that starts a whole-array erase |
| sect_erase_go | output | 1 | One-cycle pulse that starts a sector erase |
| sect_target | output | SECT_W | Sector being erased; 0 when not busy |
| erase_done | output | 1 | One-cycle pulse from the erase engine at completion |

## Verification
The assertions assume rst_n is held low for at least one clock edge before the first write. They also assume we_n is synchronous to clk and that bus_addr/bus_data are steady on the edge where the rise of we_n is detected. The bench changes every input on the falling clock edge and holds each strobe level for at least one full cycle, so every write lands as exactly one rising edge. Reset is pulled low mid-erase only at a falling edge, which keeps the async abort away from the sampling edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
   localparam int CMD_AW = 11;
   localparam logic [CMD_AW-1:0] ADR_A = 11'h555;
   localparam logic [CMD_AW-1:0] ADR_B = 11'h2AA;
   localparam logic [7:0] D_UNLK_A = 8'hAA;
   localparam logic [7:0] D_UNLK_B = 8'h55;
   localparam logic [7:0] D_SETUP  = 8'h80;
   localparam logic [7:0] D_CHIP   = 8'h10;
   localparam logic [7:0] D_SECT   = 8'h30;

   typedef enum logic [2:0] {
      ST_READ  = 3'd0,
      ST_U1    = 3'd1,
      ST_U2    = 3'd2,
      ST_SETUP = 3'd3,
      ST_U3    = 3'd4,
      ST_U4    = 3'd5,
      ST_BUSY  = 3'd6
   } seq_state_e;
endpackage

// File: rtl/we_edge_detect.sv
module we_edge_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic we_n,
   output logic strobe
);
   logic we_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) we_q <= 1'b1;
      else        we_q <= we_n;
   end

   // rising edge of the active-low strobe: was low, now high
   assign strobe = we_n & ~we_q;
endmodule

// File: rtl/erase_engine_stub.sv
module erase_engine_stub #(
   parameter int CHIP_LEN = 1000,
   parameter int SECT_LEN = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chip_go,
   input  logic sect_go,
   output logic done
);
   localparam int MAX_LEN = (CHIP_LEN > SECT_LEN) ? CHIP_LEN : SECT_LEN;
   localparam int CW      = $clog2(MAX_LEN + 1);
   localparam logic [CW-1:0] CHIP_LOAD = CW'(CHIP_LEN - 1);
   localparam logic [CW-1:0] SECT_LOAD = CW'(SECT_LEN - 1);

   logic          active;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (chip_go || sect_go) begin
            active <= 1'b1;
            cnt    <= chip_go ? CHIP_LOAD : SECT_LOAD;
         end else if (active) begin
            if (cnt == '0) begin
               active <= 1'b0;
               done   <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W            = 16,
   parameter int SECT_W            = 4,
   parameter bit RESTART_ON_UNLOCK = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        data,
   input  logic              eng_done,
   output logic              array_read,
   output logic              busy_n,
   output logic              chip_go,
   output logic              sect_go,
   output logic [SECT_W-1:0] sect_target
);
   seq_state_e state, nxt, fail_nxt;
   logic at_a, at_b, hit_unlk_a, acc_chip, acc_sect;

   assign at_a       = (addr[CMD_AW-1:0] == ADR_A);
   assign at_b       = (addr[CMD_AW-1:0] == ADR_B);
   assign hit_unlk_a = at_a && (data == D_UNLK_A);

   generate
      if (RESTART_ON_UNLOCK) begin : g_restart
         assign fail_nxt = hit_unlk_a ? ST_U1 : ST_READ;
      end else begin : g_strict
         assign fail_nxt = ST_READ;
      end
   endgenerate

   assign acc_chip = strobe && (state == ST_U4) && at_a && (data == D_CHIP);
   assign acc_sect = strobe && (state == ST_U4) && (data == D_SECT);

   always_comb begin
      nxt = state;
      if (state == ST_BUSY) begin
         if (eng_done) nxt = ST_READ;
      end else if (strobe) begin
         unique case (state)
            ST_READ:  nxt = hit_unlk_a ? ST_U1 : ST_READ;
            ST_U1:    nxt = (at_b && data == D_UNLK_B) ? ST_U2 : fail_nxt;
            ST_U2:    nxt = (at_a && data == D_SETUP) ? ST_SETUP : fail_nxt;
            ST_SETUP: nxt = hit_unlk_a ? ST_U3 : fail_nxt;
            ST_U3:    nxt = (at_b && data == D_UNLK_B) ? ST_U4 : fail_nxt;
            ST_U4:    nxt = (acc_chip || acc_sect) ? ST_BUSY : fail_nxt;
            default:  nxt = ST_READ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_READ;
         chip_go     <= 1'b0;
         sect_go     <= 1'b0;
         sect_target <= '0;
      end else begin
         state   <= nxt;
         chip_go <= acc_chip;
         sect_go <= acc_sect;
         if (acc_sect)
            sect_target <= addr[ADDR_W-1 -: SECT_W];
         else if (state == ST_BUSY && eng_done)
            sect_target <= '0;
      end
   end

   assign array_read = (state == ST_READ);
   assign busy_n     = (state != ST_BUSY);
endmodule

// File: rtl/flash_erase_cmd_decoder.sv
module flash_erase_cmd_decoder
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W            = 16,
   parameter int SECT_W            = 4,
   parameter int CHIP_LEN          = 1000,
   parameter int SECT_LEN          = 200,
   parameter bit RESTART_ON_UNLOCK = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_data,
   output logic              array_read,
   output logic              busy_n,
   output logic              chip_erase_go,
   output logic              sect_erase_go,
   output logic [SECT_W-1:0] sect_target,
   output logic              erase_done
);
   generate
      if (ADDR_W < CMD_AW + SECT_W) begin : g_bad_addr
         $error("ADDR_W must cover the command bits plus the sector field");
      end
      if (SECT_W < 1) begin : g_bad_sect
         $error("SECT_W must be at least 1");
      end
      if (CHIP_LEN < 1 || SECT_LEN < 1) begin : g_bad_len
         $error("erase lengths must be at least 1");
      end
   endgenerate

   logic strobe;

   we_edge_detect u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_n   (we_n),
      .strobe (strobe)
   );

   cmd_seq_fsm #(
      .ADDR_W            (ADDR_W),
      .SECT_W            (SECT_W),
      .RESTART_ON_UNLOCK (RESTART_ON_UNLOCK)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .strobe      (strobe),
      .addr        (bus_addr),
      .data        (bus_data),
      .eng_done    (erase_done),
      .array_read  (array_read),
      .busy_n      (busy_n),
      .chip_go     (chip_erase_go),
      .sect_go     (sect_erase_go),
      .sect_target (sect_target)
   );

   erase_engine_stub #(
      .CHIP_LEN (CHIP_LEN),
      .SECT_LEN (SECT_LEN)
   ) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .chip_go (chip_erase_go),
      .sect_go (sect_erase_go),
      .done    (erase_done)
   );
endmodule

// File: rtl/flash_erase_cmd_checker.sv
module flash_erase_cmd_checker #(
   parameter int SECT_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              array_read,
   input logic              busy_n,
   input logic              chip_erase_go,
   input logic              sect_erase_go,
   input logic [SECT_W-1:0] sect_target,
   input logic              erase_done
);
   // R1: outputs idle while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_reset_idle: assert (busy_n && array_read && !chip_erase_go
                                  && !sect_erase_go && !erase_done);
      end
   end

   a_r2_chip_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
      chip_erase_go |-> !busy_n);

   a_r3_sect_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
      sect_erase_go |-> !busy_n);

   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      chip_erase_go |=> !chip_erase_go);

   a_r7_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_n |=> !(chip_erase_go || sect_erase_go));

   a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
      erase_done |=> (busy_n && array_read));

   a_r8_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      erase_done |-> !busy_n);

   a_r8_target_clear: assert property (@(posedge clk) disable iff (!rst_n)
      busy_n |-> (sect_target == '0));

   a_r10_not_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_n |-> !array_read);
endmodule

bind flash_erase_cmd_decoder flash_erase_cmd_checker #(.SECT_W(SECT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .array_read    (array_read),
   .busy_n        (busy_n),
   .chip_erase_go (chip_erase_go),
   .sect_erase_go (sect_erase_go),
   .sect_target   (sect_target),
   .erase_done    (erase_done)
);

// File: tb/flash_erase_cmd_decoder_tb.sv
module flash_erase_cmd_decoder_tb;
   localparam int ADDR_W   = 16;
   localparam int SECT_W   = 4;
   localparam int CHIP_LEN = 40;
   localparam int SECT_LEN = 8;
   localparam int NV       = 10;

   // entry: {addr[15:0], data[7:0], exp array_read, exp busy_n}
   localparam logic [25:0] VECS [0:NV-1] = '{
      {16'h0555, 8'hAA, 1'b0, 1'b1},
      {16'h02AA, 8'h55, 1'b0, 1'b1},
      {16'h0555, 8'h90, 1'b1, 1'b1},
      {16'h02AA, 8'h55, 1'b1, 1'b1},
      {16'h0555, 8'hAA, 1'b0, 1'b1},
      {16'h02AA, 8'h55, 1'b0, 1'b1},
      {16'h0555, 8'h80, 1'b0, 1'b1},
      {16'h0555, 8'hAA, 1'b0, 1'b1},
      {16'h02AA, 8'h55, 1'b0, 1'b1},
      {16'h0555, 8'h10, 1'b0, 1'b0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              we_n = 1'b1;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [7:0]        bus_data = '0;
   logic              array_read, busy_n, chip_erase_go, sect_erase_go, erase_done;
   logic [SECT_W-1:0] sect_target;

   int n_total = 0;
   int n_fail  = 0;
   int chip_pulses = 0, sect_pulses = 0, done_pulses = 0, busy_cycles = 0;

   always #2.5 clk = ~clk;

   flash_erase_cmd_decoder #(
      .ADDR_W   (ADDR_W),
      .SECT_W   (SECT_W),
      .CHIP_LEN (CHIP_LEN),
      .SECT_LEN (SECT_LEN)
   ) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .we_n          (we_n),
      .bus_addr      (bus_addr),
      .bus_data      (bus_data),
      .array_read    (array_read),
      .busy_n        (busy_n),
      .chip_erase_go (chip_erase_go),
      .sect_erase_go (sect_erase_go),
      .sect_target   (sect_target),
      .erase_done    (erase_done)
   );

   always @(negedge clk) begin
      if (chip_erase_go) chip_pulses <= chip_pulses + 1;
      if (sect_erase_go) sect_pulses <= sect_pulses + 1;
      if (erase_done)    done_pulses <= done_pulses + 1;
      if (!busy_n)       busy_cycles <= busy_cycles + 1;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clr_mon();
      chip_pulses = 0; sect_pulses = 0; done_pulses = 0; busy_cycles = 0;
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_data = d; we_n = 1'b0;
      @(negedge clk); we_n = 1'b1;
      @(negedge clk); #1;
   endtask

   task automatic prefix();
      bus_write(16'h0555, 8'hAA);
      bus_write(16'h02AA, 8'h55);
      bus_write(16'h0555, 8'h80);
      bus_write(16'h0555, 8'hAA);
      bus_write(16'h02AA, 8'h55);
   endtask

   task automatic wait_idle();
      while (!busy_n) @(negedge clk);
      #1;
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_total++; n_fail++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      report();
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      #1;
      chk("R1 busy_n in reset", busy_n, 1);
      chk("R1 array_read in reset", array_read, 1);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1 starts idle", {chip_erase_go, sect_erase_go, erase_done}, 0);
      chk("R1 sect_target zero", sect_target, 0);

      // table: R4 mismatch recovery, R10 read flag, R2 chip start
      clr_mon();
      for (int i = 0; i < NV; i++) begin
         bus_write(VECS[i][25:10], VECS[i][9:2]);
         chk($sformatf("R10/R4 array_read vec %0d", i), array_read, VECS[i][1]);
         chk($sformatf("R2 busy_n vec %0d", i), busy_n, VECS[i][0]);
      end
      chk("R2 chip pulse at accept", chip_erase_go, 1);
      wait_idle();
      chk("R2 one chip pulse", chip_pulses, 1);
      chk("R6 chip busy cycles", busy_cycles, CHIP_LEN + 2);
      chk("R8 one done pulse", done_pulses, 1);
      chk("R8 array_read after done", array_read, 1);
      chk("R4 no sector pulse", sect_pulses, 0);

      // R3 sector erase with target from upper address bits
      clr_mon();
      prefix();
      bus_write(16'hA123, 8'h30);
      chk("R3 sector pulse", sect_erase_go, 1);
      chk("R3 sect_target", sect_target, 4'hA);
      chk("R3 busy", busy_n, 0);
      wait_idle();
      chk("R6 sector busy cycles", busy_cycles, SECT_LEN + 2);
      chk("R3 one sector pulse", sect_pulses, 1);
      chk("R8 sect_target cleared", sect_target, 0);
      chk("R8 done once", done_pulses, 1);

      // R7 writes during busy are ignored
      clr_mon();
      prefix();
      bus_write(16'h0555, 8'h10);
      prefix();
      bus_write(16'h7000, 8'h30);
      chk("R7 still busy", busy_n, 0);
      wait_idle();
      chk("R7 no sector start", sect_pulses, 0);
      chk("R7 single chip start", chip_pulses, 1);
      chk("R7 busy time unchanged", busy_cycles, CHIP_LEN + 2);

      // R5 only the value at the rising edge counts
      @(negedge clk); bus_addr = 16'h0555; bus_data = 8'hAA; we_n = 1'b0;
      repeat (3) @(negedge clk);
      bus_data = 8'h00;
      @(negedge clk); we_n = 1'b1;
      @(negedge clk); #1;
      chk("R5 data changed before rise ignored", array_read, 1);
      @(negedge clk); bus_data = 8'h00; we_n = 1'b0;
      @(negedge clk); bus_data = 8'hAA;
      @(negedge clk); we_n = 1'b1;
      @(negedge clk); #1;
      chk("R5 value at rise taken", array_read, 0);
      @(negedge clk); bus_addr = 16'h02AA; bus_data = 8'h55;
      repeat (3) @(negedge clk);
      #1;
      chk("R5 no strobe no advance", array_read, 0);
      bus_write(16'h0555, 8'h00);
      chk("R4 mismatch returns to read", array_read, 1);

      // R9 reset aborts erase
      clr_mon();
      prefix();
      bus_write(16'h3000, 8'h30);
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R9 busy_n released at once", busy_n, 1);
      chk("R9 array_read at once", array_read, 1);
      @(negedge clk); rst_n = 1'b1;
      repeat (SECT_LEN + 6) @(negedge clk);
      #1;
      chk("R9 no done after abort", done_pulses, 0);
      chk("R9 sect_target cleared", sect_target, 0);

      report();
   end
endmodule